// File: doc/BRIEF.md
# Dual-Read-Port Operand Stack

This block is the operand store of a multi-cycle stack processor. It holds up to `DEPTH` words of `WIDTH` bits under a pointer that always marks the first free slot. Two combinational read ports show the two newest entries. One write port pushes a new word. Four plain strobes from the processor's sequencer drive it: push, pop-one, pop-two and clear. It has no read strobe. Reading never moves the pointer, so the datapath can consume operands and store a result within a single machine cycle.

The pointer, the storage and the error flags change only on the falling clock edge. The datapath therefore reads operands during the high phase, and the stack settles before the next rising edge. The control pins are plain level strobes sampled at a falling edge. There is no valid/ready handshake: the stack accepts one operation on every falling edge and never applies back-pressure. Illegal operations are refused, and each one sets a sticky exception flag that the processor can turn into a trap.

Top module: `operand_stack`

## Requirements
- R1: A push (`push_i`) with fewer than `DEPTH` entries writes `push_data_i` into the slot at the pointer and advances the pointer by one. The pushed word then appears on `top_o`, and the previous top moves to `next_o`.
- R2: `pop1_i` lowers the pointer by one entry, and `pop2_i` lowers it by two. The stored words below the new pointer are unchanged.
- R3: `clear_i` empties the stack and clears both exception flags.
- R4: When several strobes are asserted in the same cycle, only one acts. The order of precedence is clear, then pop-two, then pop-one, then push.
- R5: `top_o` shows the entry at pointer-1 and `next_o` shows the entry at pointer-2. Neither needs a strobe, and idle cycles leave both unchanged.
- R6: A push that acts while the stack holds `DEPTH` entries changes neither the pointer nor the storage. It sets `ovf_o`, which stays set until clear or reset.
- R7: A pop-one on an empty stack, or a pop-two with fewer than two entries, changes neither the pointer nor the storage. It sets `unf_o`, which stays set until clear or reset.
- R8: A read port whose entry does not exist drives zero.
- R9: All state changes take effect on the falling clock edge, and a rising edge changes nothing. The reset `rst_ni` is active-low and synchronous, sampled on the falling edge. It empties the stack and clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; state updates on its falling edge |
| rst_ni | input | 1 | Synchronous active-low reset |
| push_i | input | 1 | Push strobe |
| pop1_i | input | 1 | Pop-one strobe |
| pop2_i | input | 1 | Pop-two strobe |
| clear_i | input | 1 | Clear strobe |
| push_data_i | input | WIDTH | Word written by a push |
| top_o | output | WIDTH | Entry at pointer-1, or zero |
| next_o | output | WIDTH | Entry at pointer-2, or zero |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |

## Verification
The strobes are sampled at one falling edge. Every result (the read ports and both flags) is due just after that same edge, with no further latency, because the read ports are combinational from the pointer and the storage. The driver applies each strobe half a nanosecond after a falling edge and queues the expected result. The monitor compares one nanosecond after the next falling edge. A separate check samples the read ports just after the intervening rising edge and confirms that nothing has moved yet.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_PUSH,
    OP_POP1,
    OP_POP2,
    OP_CLEAR
  } stk_op_e;
endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic          push_i,
  input  logic          pop1_i,
  input  logic          pop2_i,
  input  logic          clear_i,
  input  logic [PW-1:0] ptr_i,
  output stk_op_e       op_o,
  output logic          ovf_now_o,
  output logic          unf_now_o
);
  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  // precedence: clear, pop-two, pop-one, push (R4)
  always_comb begin
    op_o      = OP_NONE;
    ovf_now_o = 1'b0;
    unf_now_o = 1'b0;
    if (clear_i) begin
      op_o = OP_CLEAR;
    end else if (pop2_i) begin
      if (ptr_i < PW'(2)) unf_now_o = 1'b1;
      else                op_o      = OP_POP2;
    end else if (pop1_i) begin
      if (ptr_i == '0) unf_now_o = 1'b1;
      else             op_o      = OP_POP1;
    end else if (push_i) begin
      if (ptr_i == FULL) ovf_now_o = 1'b1;
      else               op_o      = OP_PUSH;
    end
  end
endmodule

// File: rtl/stk_regfile.sv
module stk_regfile #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  localparam int PW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [PW-1:0]    ptr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] top_o,
  output logic [WIDTH-1:0] next_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    idx_top, idx_next;

  always_ff @(negedge clk_i) begin
    if (we_i) mem_q[ptr_i[AW-1:0]] <= wdata_i;
  end

  assign idx_top  = ptr_i - PW'(1);
  assign idx_next = ptr_i - PW'(2);

  // absent entries read as zero (R8)
  always_comb begin
    top_o  = (ptr_i >= PW'(1)) ? mem_q[idx_top[AW-1:0]]  : '0;
    next_o = (ptr_i >= PW'(2)) ? mem_q[idx_next[AW-1:0]] : '0;
  end
endmodule

// File: rtl/operand_stack.sv
module operand_stack
  import stk_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 16,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop1_i,
  input  logic             pop2_i,
  input  logic             clear_i,
  input  logic [WIDTH-1:0] push_data_i,
  output logic [WIDTH-1:0] top_o,
  output logic [WIDTH-1:0] next_o,
  output logic             ovf_o,
  output logic             unf_o
);
  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  stk_op_e       op;
  logic          ovf_now, unf_now;
  logic [PW-1:0] ptr_q;
  logic          ovf_q, unf_q;

  stk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .push_i    (push_i),
    .pop1_i    (pop1_i),
    .pop2_i    (pop2_i),
    .clear_i   (clear_i),
    .ptr_i     (ptr_q),
    .op_o      (op),
    .ovf_now_o (ovf_now),
    .unf_now_o (unf_now)
  );

  stk_regfile #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rf (
    .clk_i   (clk_i),
    .we_i    (op == OP_PUSH),
    .ptr_i   (ptr_q),
    .wdata_i (push_data_i),
    .top_o   (top_o),
    .next_o  (next_o)
  );

  always_ff @(negedge clk_i) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      unique case (op)
        OP_CLEAR: begin
          ptr_q <= '0;
          ovf_q <= 1'b0;
          unf_q <= 1'b0;
        end
        OP_PUSH: ptr_q <= ptr_q + PW'(1);
        OP_POP1: ptr_q <= ptr_q - PW'(1);
        OP_POP2: ptr_q <= ptr_q - PW'(2);
        default: ;
      endcase
      if (ovf_now) ovf_q <= 1'b1;
      if (unf_now) unf_q <= 1'b1;
    end
  end

  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

  p_ptr_bound_r6: assert property (@(negedge clk_i) disable iff (!rst_ni)
    ptr_q <= FULL);

  p_push_top_r1: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (push_i && !pop1_i && !pop2_i && !clear_i && ptr_q < FULL)
    |=> (top_o == $past(push_data_i)) && (ptr_q == $past(ptr_q) + PW'(1)));

  p_pop2_step_r2: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (pop2_i && !clear_i && ptr_q >= PW'(2)) |=> ptr_q == $past(ptr_q) - PW'(2));

  p_clear_r3: assert property (@(negedge clk_i) disable iff (!rst_ni)
    clear_i |=> (ptr_q == '0) && !ovf_o && !unf_o);

  p_no_overflow_r6: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (push_i && !pop1_i && !pop2_i && !clear_i && ptr_q == FULL)
    |=> $stable(ptr_q) && ovf_o);

  p_no_underflow_r7: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (pop1_i && !pop2_i && !clear_i && ptr_q == '0) |=> $stable(ptr_q) && unf_o);

  p_empty_zero_r8: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (ptr_q == '0) |-> (top_o == '0) && (next_o == '0));
endmodule

// File: tb/test_operand_stack.sv
`timescale 1ns/1ps
module test_operand_stack;
  localparam int DEPTH = 16;
  localparam int WIDTH = 16;

  typedef struct {
    logic [WIDTH-1:0] a;
    logic [WIDTH-1:0] b;
    logic             o;
    logic             u;
    string            tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up = 1'b0, d1 = 1'b0, d2 = 1'b0, cl = 1'b0;
  logic [WIDTH-1:0] sd = '0;
  logic [WIDTH-1:0] a_data, b_data;
  logic ovf, unf;

  int checks = 0;
  int errors = 0;
  exp_t q[$];

  logic [WIDTH-1:0] m [DEPTH];
  int cnt = 0;
  logic mo = 1'b0, mu = 1'b0;

  always #2.5 clk = ~clk;

  operand_stack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_operand_stack (
    .clk_i(clk), .rst_ni(rst_n), .push_i(up), .pop1_i(d1), .pop2_i(d2),
    .clear_i(cl), .push_data_i(sd), .top_o(a_data), .next_o(b_data),
    .ovf_o(ovf), .unf_o(unf)
  );

  function automatic logic [WIDTH-1:0] exp_a();
    return (cnt >= 1) ? m[cnt-1] : '0;
  endfunction
  function automatic logic [WIDTH-1:0] exp_b();
    return (cnt >= 2) ? m[cnt-2] : '0;
  endfunction

  task automatic model(input bit u, input bit p1, input bit p2, input bit c,
                       input logic [WIDTH-1:0] s, input bit rst);
    if (rst || c) begin
      cnt = 0; mo = 1'b0; mu = 1'b0;
    end else if (p2) begin
      if (cnt < 2) mu = 1'b1; else cnt -= 2;
    end else if (p1) begin
      if (cnt < 1) mu = 1'b1; else cnt -= 1;
    end else if (u) begin
      if (cnt == DEPTH) mo = 1'b1;
      else begin m[cnt] = s; cnt += 1; end
    end
  endtask

  task automatic push_exp(input string tag);
    exp_t e;
    e.a = exp_a(); e.b = exp_b(); e.o = mo; e.u = mu; e.tag = tag;
    q.push_back(e);
  endtask

  // driver: strobes sampled at the next falling edge, result due right after
  task automatic step(input bit u, input bit p1, input bit p2, input bit c,
                      input logic [WIDTH-1:0] s, input string tag);
    up = u; d1 = p1; d2 = p2; cl = c; sd = s;
    @(negedge clk); #0.5;
    up = 0; d1 = 0; d2 = 0; cl = 0;
    model(u, p1, p2, c, s, !rst_n);
    push_exp(tag);
  endtask

  // monitor
  initial forever begin
    @(negedge clk); #1;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (a_data !== e.a || b_data !== e.b || ovf !== e.o || unf !== e.u) begin
        errors++;
        $display("FAIL %s: got a=%h b=%h ovf=%b unf=%b exp a=%h b=%h ovf=%b unf=%b",
                 e.tag, a_data, b_data, ovf, unf, e.a, e.b, e.o, e.u);
      end
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    #0.5;
    step(0, 0, 0, 0, '0, "R9 reset");
    step(1, 0, 0, 0, 16'hdead, "R9 push ignored in reset");
    rst_n = 1'b1;
    step(0, 0, 0, 0, '0, "R8 empty reads zero");
    step(1, 0, 0, 0, 16'h1111, "R1 R8 one item");
    step(1, 0, 0, 0, 16'h2222, "R1 second push");
    // R9: nothing moves at the rising edge
    up = 1; sd = 16'h3333;
    @(posedge clk); #0.5;
    checks++;
    if (a_data !== 16'h2222) begin
      errors++;
      $display("FAIL R9 rising edge: got %h exp %h", a_data, 16'h2222);
    end
    @(negedge clk); #0.5;
    up = 0;
    model(1, 0, 0, 0, 16'h3333, 0);
    push_exp("R9 R1 update at falling edge");
    step(0, 0, 0, 0, '0, "R5 idle hold");
    step(0, 0, 0, 0, '0, "R5 idle hold again");
    step(0, 1, 0, 0, '0, "R2 pop one");
    step(1, 0, 0, 0, 16'h4444, "R1 push after pop");
    step(0, 0, 1, 0, '0, "R2 pop two");
    step(0, 0, 1, 0, '0, "R7 pop two with one item");
    step(0, 1, 0, 0, '0, "R2 pop last item");
    step(0, 1, 0, 0, '0, "R7 pop one on empty");
    step(1, 0, 0, 0, 16'h5555, "R7 flag sticky after good push");
    step(0, 0, 0, 1, '0, "R3 clear");
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 0, WIDTH'(16'h0100 + i), "R1 fill");
    step(1, 0, 0, 0, 16'hbeef, "R6 overflow refused");
    step(0, 0, 0, 0, '0, "R6 flag sticky");
    step(1, 1, 1, 0, 16'hcafe, "R4 pop two beats pop one and push");
    step(1, 1, 0, 0, 16'hcafe, "R4 pop one beats push");
    step(1, 1, 1, 1, 16'hcafe, "R4 R3 clear beats all");
    step(1, 0, 0, 0, 16'h7777, "R1 push after clear");
    step(1, 0, 0, 0, 16'h8888, "R1 push");
    rst_n = 1'b0;
    step(0, 0, 0, 0, '0, "R9 sync reset empties");
    rst_n = 1'b1;
    step(0, 0, 0, 0, '0, "R8 idle after reset");
    @(negedge clk); #2;
    finish_run();
  end
endmodule